// File: doc/BRIEF.md
# Same-Cycle Rename Source Forwarding

This block is the combinational correction network of a rename stage that handles a group of several instructions per cycle. Every instruction names two source architectural registers (A and B) and at most one destination. The map table is read for all sources of the group at once, and it sees no writes made by the group itself. A free list has already allocated a new physical register for each destination. The block takes the map lookups, the architectural register numbers and the new physical destinations. It produces the corrected physical source for every slot.

A source that names a register written by an earlier slot of the same group gets that slot's new physical register in place of the stale lookup. When several earlier slots write that register, the closest preceding slot wins. The block also produces one map-write enable per slot. Only the last writer of any architectural register in the group updates the map. Slots that are not valid, slots without a destination, and slots whose destination is register 0 take no part in forwarding and never write the map.

Top module: `rename_group_bypass`

## Requirements
- R1: The physical sources of slot 0 always equal its map lookups.
- R2: When exactly one earlier slot is a qualifying writer of a source's architectural register, the source takes that slot's new physical destination.
- R3: When more than one earlier slot is a qualifying writer of the same register, the source takes the destination of the nearest preceding one, which is the highest-numbered slot below it.
- R4: A source with no qualifying earlier writer keeps its map lookup.
- R5: A slot whose destination enable is 0, or whose destination number is 0, is never a qualifying writer and never raises its map-write enable.
- R6: An invalid slot is never a qualifying writer and never raises its map-write enable.
- R7: The map-write enable of a slot is 1 only when the slot is a qualifying writer and no later slot is a qualifying writer of the same register. With every slot invalid, all enables are 0.
- R8: Sources A and B of one slot are corrected independently, so each may take a different earlier slot's destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slot_valid | input | LANES | Slot holds an instruction, bit i for slot i (slot 0 oldest) |
| dst_en | input | LANES | Slot writes a destination register |
| src_a_arch | input | LANES*AREG_W | Source A architectural number, slot i at bits i*AREG_W |
| src_b_arch | input | LANES*AREG_W | Source B architectural number |
| dst_arch | input | LANES*AREG_W | Destination architectural number |
| src_a_map | input | LANES*PREG_W | Map lookup for source A, slot i at bits i*PREG_W |
| src_b_map | input | LANES*PREG_W | Map lookup for source B |
| dst_phys | input | LANES*PREG_W | New physical destination allocated to each slot |
| src_a_phys | output | LANES*PREG_W | Corrected physical source A |
| src_b_phys | output | LANES*PREG_W | Corrected physical source B |
| map_wr | output | LANES | Slot's destination mapping is written to the map |

## Verification
The assertions assume that the inputs are settled whenever they are evaluated. They also assume that a source's result can always be traced to its own lookup or to an earlier slot's new destination. This holds only because the block never makes up a physical number. The stimulus changes all inputs together at one clock edge and compares outputs at the opposite edge. Random groups draw register numbers from a tiny range, so same-group collisions, repeated writers and register 0 occur often. Lookups and new destinations come from disjoint number ranges, so a forwarded value can never be confused with a lookup.

// File: rtl/rename_group_bypass.sv
module rename_group_bypass #(
  parameter int LANES  = 4,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7
) (
  input  logic [LANES-1:0]        slot_valid,
  input  logic [LANES-1:0]        dst_en,
  input  logic [LANES*AREG_W-1:0] src_a_arch,
  input  logic [LANES*AREG_W-1:0] src_b_arch,
  input  logic [LANES*AREG_W-1:0] dst_arch,
  input  logic [LANES*PREG_W-1:0] src_a_map,
  input  logic [LANES*PREG_W-1:0] src_b_map,
  input  logic [LANES*PREG_W-1:0] dst_phys,
  output logic [LANES*PREG_W-1:0] src_a_phys,
  output logic [LANES*PREG_W-1:0] src_b_phys,
  output logic [LANES-1:0]        map_wr
);

  logic [LANES-1:0] writer;

  for (genvar g = 0; g < LANES; g++) begin : g_writer
    assign writer[g] = slot_valid[g] && dst_en[g] && (dst_arch[g*AREG_W +: AREG_W] != '0);
  end

  // ascending scan: a later match overrides, so the nearest older writer wins
  always_comb begin
    src_a_phys = src_a_map;
    src_b_phys = src_b_map;
    for (int i = 1; i < LANES; i++) begin
      for (int j = 0; j < LANES; j++) begin
        if (j < i && writer[j]) begin
          if (dst_arch[j*AREG_W +: AREG_W] == src_a_arch[i*AREG_W +: AREG_W])
            src_a_phys[i*PREG_W +: PREG_W] = dst_phys[j*PREG_W +: PREG_W];
          if (dst_arch[j*AREG_W +: AREG_W] == src_b_arch[i*AREG_W +: AREG_W])
            src_b_phys[i*PREG_W +: PREG_W] = dst_phys[j*PREG_W +: PREG_W];
        end
      end
    end
  end

  always_comb begin
    map_wr = writer;
    for (int i = 0; i < LANES; i++)
      for (int j = 0; j < LANES; j++)
        if (j > i && writer[j] && dst_arch[j*AREG_W +: AREG_W] == dst_arch[i*AREG_W +: AREG_W])
          map_wr[i] = 1'b0;
  end

  always_comb begin
    assert_lane0_unchanged_R1: assert (src_a_phys[PREG_W-1:0] == src_a_map[PREG_W-1:0] &&
                                       src_b_phys[PREG_W-1:0] == src_b_map[PREG_W-1:0]);
    for (int i = 0; i < LANES; i++) begin
      assert_write_qualified_R5: assert (!map_wr[i] ||
        (slot_valid[i] && dst_en[i] && dst_arch[i*AREG_W +: AREG_W] != '0));
      for (int j = i + 1; j < LANES; j++)
        assert_single_writer_R7: assert (!(map_wr[i] && map_wr[j]) ||
          dst_arch[i*AREG_W +: AREG_W] != dst_arch[j*AREG_W +: AREG_W]);
    end
  end

  // R2 R4: every source result is its own lookup or an older slot's new register
  always_comb begin
    for (int i = 1; i < LANES; i++) begin
      automatic logic ok_a = (src_a_phys[i*PREG_W +: PREG_W] == src_a_map[i*PREG_W +: PREG_W]);
      automatic logic ok_b = (src_b_phys[i*PREG_W +: PREG_W] == src_b_map[i*PREG_W +: PREG_W]);
      for (int j = 0; j < LANES; j++) begin
        if (j < i && src_a_phys[i*PREG_W +: PREG_W] == dst_phys[j*PREG_W +: PREG_W]) ok_a = 1'b1;
        if (j < i && src_b_phys[i*PREG_W +: PREG_W] == dst_phys[j*PREG_W +: PREG_W]) ok_b = 1'b1;
      end
      assert_source_origin_R2: assert (ok_a && ok_b);
    end
  end

endmodule

// File: tb/tb_rename_group_bypass.sv
module tb_rename_group_bypass;
  localparam int L  = 4;
  localparam int AW = 5;
  localparam int PW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [L-1:0]    slot_valid, dst_en, map_wr;
  logic [L*AW-1:0] src_a_arch, src_b_arch, dst_arch;
  logic [L*PW-1:0] src_a_map, src_b_map, dst_phys, src_a_phys, src_b_phys;

  rename_group_bypass #(.LANES(L), .AREG_W(AW), .PREG_W(PW)) dut (
    .slot_valid(slot_valid), .dst_en(dst_en), .src_a_arch(src_a_arch),
    .src_b_arch(src_b_arch), .dst_arch(dst_arch), .src_a_map(src_a_map),
    .src_b_map(src_b_map), .dst_phys(dst_phys), .src_a_phys(src_a_phys),
    .src_b_phys(src_b_phys), .map_wr(map_wr));

  int v[L], en[L], ra[L], rb[L], rd[L], ma[L], mb[L], pd[L];
  int checks = 0, fails = 0, cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drive();
    @(posedge clk);
    for (int i = 0; i < L; i++) begin
      slot_valid[i] = v[i][0];
      dst_en[i]     = en[i][0];
      src_a_arch[i*AW +: AW] = AW'(ra[i]);
      src_b_arch[i*AW +: AW] = AW'(rb[i]);
      dst_arch[i*AW +: AW]   = AW'(rd[i]);
      src_a_map[i*PW +: PW]  = PW'(ma[i]);
      src_b_map[i*PW +: PW]  = PW'(mb[i]);
      dst_phys[i*PW +: PW]   = PW'(pd[i]);
    end
  endtask

  task automatic chk(string req, string focus, int lane, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s lane %0d: actual %0d expected %0d", req, focus, lane, got, exp);
    end
  endtask

  function automatic bit qual(int j);
    return v[j] != 0 && en[j] != 0 && rd[j] != 0;
  endfunction

  task automatic src_check(string focus, int i, int r, int m, int got);
    int exp = m, hits = 0;
    string req;
    for (int j = 0; j < i; j++) if (qual(j) && rd[j] == r) hits++;
    for (int j = i - 1; j >= 0; j--)
      if (qual(j) && rd[j] == r) begin exp = pd[j]; break; end
    if (i == 0) req = "R1";
    else if (hits > 1) req = "R3";
    else if (hits == 1) req = "R2";
    else req = "R4";
    chk(req, focus, i, got, exp);
  endtask

  task automatic compare(string focus);
    @(negedge clk);
    for (int i = 0; i < L; i++) begin
      int exp_we;
      src_check(focus, i, ra[i], ma[i], int'(src_a_phys[i*PW +: PW]));
      src_check(focus, i, rb[i], mb[i], int'(src_b_phys[i*PW +: PW]));
      exp_we = qual(i) ? 1 : 0;
      for (int j = i + 1; j < L; j++) if (qual(i) && qual(j) && rd[j] == rd[i]) exp_we = 0;
      chk("R7", focus, i, int'(map_wr[i]), exp_we);
    end
  endtask

  task automatic base();
    for (int i = 0; i < L; i++) begin
      v[i] = 1; en[i] = 1; ra[i] = 20 + i; rb[i] = 24 + i; rd[i] = 10 + i;
      ma[i] = 1 + i; mb[i] = 8 + i; pd[i] = 40 + i;
    end
  endtask

  initial begin
    base();
    for (int i = 0; i < L; i++) v[i] = 0;
    drive();
    compare("reset all-invalid R7");
    rst_n = 1'b1;

    base(); drive(); compare("no collisions R4");

    base(); ra[2] = 10; rb[2] = 11; drive(); compare("independent sources R8");

    base(); rd[0] = 3; rd[1] = 3; ra[2] = 3; rb[3] = 3; drive(); compare("nearest writer R3");

    base(); rd[0] = 3; rd[1] = 3; rd[2] = 3; rd[3] = 3; ra[3] = 3; drive(); compare("all same dst R7");

    base(); en[0] = 0; rd[0] = 4; ra[1] = 4; rd[1] = 0; rb[2] = 0; drive(); compare("no dst and r0 R5");

    base(); v[0] = 0; rd[0] = 5; ra[1] = 5; rb[3] = 5; drive(); compare("invalid slot R6");

    base(); rd[3] = 2; ra[0] = 2; rd[0] = 7; ra[1] = 7; drive(); compare("lane0 and single R1 R2");

    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < L; i++) begin
        v[i]  = ($urandom_range(0, 7) != 0) ? 1 : 0;
        en[i] = ($urandom_range(0, 5) != 0) ? 1 : 0;
        ra[i] = $urandom_range(0, 3);
        rb[i] = $urandom_range(0, 3);
        rd[i] = $urandom_range(0, 3);
        ma[i] = $urandom_range(1, 31);
        mb[i] = $urandom_range(1, 31);
        pd[i] = 32 + 20 * i + $urandom_range(0, 19);
      end
      drive();
      compare("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule